// File: doc/BRIEF.md
# Brown-out Hibernate Snapshot Controller

This controller keeps a small processing system running when its supply comes and goes. Two digital comparator flags tell it about the supply. One flag says the supply has fallen to or below a hibernate level. The other says it has risen to or above a higher restore level. While the core runs, a sustained low flag makes the controller halt the core. It then copies every register and the whole volatile RAM into non-volatile memory once, and sleeps. While it sleeps, a sustained high flag makes it copy that image back and release the core. The gap between the two levels gives hysteresis, so restoring does not itself pull the supply back under the hibernate level.

A validity word at non-volatile address 0 records whether a complete snapshot exists. It is cleared before a save begins and set only after the program counter has been stored, so a save cut short by power loss never looks valid. After reset the controller reads this word. A valid image is restored at once; otherwise the core starts from scratch. All three memory ports are plain synchronous single-port interfaces with a fixed one-cycle read latency. They have no valid/ready handshake: the memories must accept one access per cycle and never apply back-pressure. The comparator and status pins are plain levels.

Top module: `hib_ctrl`

## Requirements
- R1: The block has two modes. In active mode `core_run_o`=1 and `mode_hib_o`=0. In every other state `core_run_o`=0 and `mode_hib_o`=1. Mode changes only on supply events, a completed save or restore, or reset.
- R2: Both comparator inputs pass a two-flop synchronizer and must then read 1 on two consecutive synchronized samples. In active mode only the low flag is acted on; a one-cycle pulse on it starts nothing.
- R3: A save writes non-volatile memory in this order: address 0 with value 0; core registers; RAM words 0 upward; general registers; SP; PC; address 0 with value 1. Register index map: general registers at 0..GEN_REGS-1, then core registers, then SP, then PC as the last index. RAM word i is stored at address 1+i, and register j at address 1+RAM_WORDS+j.
- R4: Exactly one snapshot is written per outage. In sleep no non-volatile write occurs, however long the low flag stays set.
- R5: In sleep a qualified high flag starts a restore. The restore writes general registers first, then RAM, then core registers, SP and PC, using the R3 address map. The core is released only after the PC has been written.
- R6: A high flag that appears while a save is running is held back. No RAM or register write happens before the validity word has been set to 1.
- R7: After reset the validity word is read. The value 1 starts a restore without waiting for the high flag. Any other value starts active mode with no memory write. A save cut off by reset leaves the word at 0.
- R8: `busy_o` is 1 during save and restore. While `busy_o` or any RAM or register write is active, `core_run_o` is 0.
- R9: `hib_count_o` rises by one on each entry to sleep, saturates at its all-ones value, and changes at no other time except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_low_i | input | 1 | Supply at or below the hibernate level (asynchronous) |
| sup_high_i | input | 1 | Supply at or above the restore level (asynchronous) |
| core_run_o | output | 1 | Core released and running |
| mode_hib_o | output | 1 | 1 when not in active mode |
| busy_o | output | 1 | Save or restore in progress |
| hib_count_o | output | CNT_W | Saturating count of completed hibernations |
| ram_re_o | output | 1 | RAM read enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | clog2(RAM_WORDS) | RAM word address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after the read |
| reg_re_o | output | 1 | Register-file read enable |
| reg_we_o | output | 1 | Register-file write enable |
| reg_addr_o | output | clog2(REG_WORDS) | Register index |
| reg_wdata_o | output | DW | Register write data |
| reg_rdata_i | input | DW | Register read data, one cycle after the read |
| nvm_re_o | output | 1 | Non-volatile read enable |
| nvm_we_o | output | 1 | Non-volatile write enable |
| nvm_addr_o | output | clog2(1+RAM_WORDS+REG_WORDS) | Non-volatile word address |
| nvm_wdata_o | output | DW | Non-volatile write data |
| nvm_rdata_i | input | DW | Non-volatile read data, one cycle after the read |

## Verification
The assertions assume that every memory returns read data exactly one cycle after its read enable and takes a write in the same cycle, with no stall. They also assume that reset is the only way a save or restore is cut short. The bench models each memory as an array with that exact timing. It changes the comparator flags only on falling clock edges, and it stops an operation only by asserting reset. A forced power loss is modelled by overwriting the volatile arrays while the controller sleeps.

// File: rtl/hib_pkg.sv
package hib_pkg;
  // Controller states; order carries no meaning.
  typedef enum logic [3:0] {
    ST_BOOT,     // read validity word
    ST_BOOTCHK,  // decide restore or init
    ST_RUN,      // active mode, core released
    ST_CLR,      // invalidate snapshot, launch save
    ST_SAVE,     // copy volatile -> non-volatile
    ST_SET,      // mark snapshot valid
    ST_SLEEP,    // wait for supply recovery
    ST_REST,     // launch restore
    ST_RWAIT     // copy non-volatile -> volatile
  } hib_state_t;
endpackage

// File: rtl/hib_sync.sv
// Two-flop synchronizer plus a two-sample agreement qualifier per bit.
module hib_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] qual_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw_i[b];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign qual_o[b] = s2 & s3;
  end
endmodule

// File: rtl/hib_seq.sv
// Walks the segment list of a save or restore, one volatile index per cycle.
module hib_seq #(
  parameter int RAM_W = 1024,
  parameter int NGEN  = 512,
  parameter int NCORE = 10,
  parameter int IW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          restore_i,
  output logic          run_o,
  output logic          dir_o,
  output logic          ram_o,
  output logic [IW-1:0] idx_o
);
  logic          run_q, dir_q;
  logic [1:0]    seg_q;
  logic [IW-1:0] cnt_q;
  logic          seg_ram;
  int            base_i, len_i;
  logic [1:0]    last_seg;
  logic          seg_end;

  // Save:    core | RAM | general | SP,PC
  // Restore: general | RAM | core,SP,PC
  always_comb begin
    seg_ram = 1'b0;
    base_i  = 0;
    len_i   = 1;
    unique case ({dir_q, seg_q})
      3'b000: begin base_i = NGEN;         len_i = NCORE;     end
      3'b001: begin seg_ram = 1'b1;        len_i = RAM_W;     end
      3'b010: begin base_i = 0;            len_i = NGEN;      end
      3'b011: begin base_i = NGEN + NCORE; len_i = 2;         end
      3'b100: begin base_i = 0;            len_i = NGEN;      end
      3'b101: begin seg_ram = 1'b1;        len_i = RAM_W;     end
      3'b110: begin base_i = NGEN;         len_i = NCORE + 2; end
      default: begin base_i = 0;           len_i = 1;         end
    endcase
  end

  assign last_seg = dir_q ? 2'd2 : 2'd3;
  assign seg_end  = (int'(cnt_q) == len_i - 1);
  assign run_o    = run_q;
  assign dir_o    = dir_q;
  assign ram_o    = seg_ram;
  assign idx_o    = IW'(base_i + int'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      seg_q <= 2'd0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      dir_q <= restore_i;
      seg_q <= 2'd0;
      cnt_q <= '0;
    end else if (run_q) begin
      if (seg_end) begin
        cnt_q <= '0;
        seg_q <= seg_q + 2'd1;
        if (seg_q == last_seg) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hib_copy.sv
// One-stage copy pipe: read at issue, write the returned word a cycle later.
module hib_copy #(
  parameter int DW    = 8,
  parameter int RAM_W = 1024,
  parameter int IW    = 10,
  parameter int RAW   = 10,
  parameter int GAW   = 10,
  parameter int NAW   = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_vld_i,
  input  logic           iss_dir_i,
  input  logic           iss_ram_i,
  input  logic [IW-1:0]  iss_idx_i,
  output logic           busy_o,
  output logic           ram_re_o,
  output logic           ram_we_o,
  output logic [RAW-1:0] ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o,
  input  logic [DW-1:0]  ram_rdata_i,
  output logic           reg_re_o,
  output logic           reg_we_o,
  output logic [GAW-1:0] reg_addr_o,
  output logic [DW-1:0]  reg_wdata_o,
  input  logic [DW-1:0]  reg_rdata_i,
  output logic           nvm_re_o,
  output logic           nvm_we_o,
  output logic [NAW-1:0] nvm_addr_o,
  output logic [DW-1:0]  nvm_wdata_o,
  input  logic [DW-1:0]  nvm_rdata_i
);
  logic          w_vld, w_dir, w_ram;
  logic [IW-1:0] w_idx;
  logic          wr_vol, wr_nvm;

  function automatic logic [NAW-1:0] nvm_map(input logic is_ram, input logic [IW-1:0] idx);
    return is_ram ? NAW'(1 + int'(idx)) : NAW'(1 + RAM_W + int'(idx));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_vld <= 1'b0;
      w_dir <= 1'b0;
      w_ram <= 1'b0;
      w_idx <= '0;
    end else begin
      w_vld <= iss_vld_i;
      if (iss_vld_i) begin
        w_dir <= iss_dir_i;
        w_ram <= iss_ram_i;
        w_idx <= iss_idx_i;
      end
    end
  end

  assign busy_o = w_vld;
  assign wr_vol = w_vld & w_dir;
  assign wr_nvm = w_vld & ~w_dir;

  assign ram_re_o    = iss_vld_i & ~iss_dir_i & iss_ram_i;
  assign ram_we_o    = wr_vol & w_ram;
  assign ram_addr_o  = (wr_vol & w_ram) ? w_idx[RAW-1:0] : iss_idx_i[RAW-1:0];
  assign ram_wdata_o = nvm_rdata_i;

  assign reg_re_o    = iss_vld_i & ~iss_dir_i & ~iss_ram_i;
  assign reg_we_o    = wr_vol & ~w_ram;
  assign reg_addr_o  = (wr_vol & ~w_ram) ? w_idx[GAW-1:0] : iss_idx_i[GAW-1:0];
  assign reg_wdata_o = nvm_rdata_i;

  assign nvm_re_o    = iss_vld_i & iss_dir_i;
  assign nvm_we_o    = wr_nvm;
  assign nvm_addr_o  = wr_nvm ? nvm_map(w_ram, w_idx) : nvm_map(iss_ram_i, iss_idx_i);
  assign nvm_wdata_o = w_ram ? ram_rdata_i : reg_rdata_i;
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RAM_WORDS = 1024,
  parameter int GEN_REGS  = 512,
  parameter int CORE_REGS = 10,
  parameter int CNT_W     = 8,
  localparam int REG_WORDS = GEN_REGS + CORE_REGS + 2,
  localparam int NVM_WORDS = 1 + RAM_WORDS + REG_WORDS,
  localparam int RAW       = $clog2(RAM_WORDS),
  localparam int GAW       = $clog2(REG_WORDS),
  localparam int NAW       = $clog2(NVM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_low_i,
  input  logic             sup_high_i,
  output logic             core_run_o,
  output logic             mode_hib_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] hib_count_o,
  output logic             ram_re_o,
  output logic             ram_we_o,
  output logic [RAW-1:0]   ram_addr_o,
  output logic [DW-1:0]    ram_wdata_o,
  input  logic [DW-1:0]    ram_rdata_i,
  output logic             reg_re_o,
  output logic             reg_we_o,
  output logic [GAW-1:0]   reg_addr_o,
  output logic [DW-1:0]    reg_wdata_o,
  input  logic [DW-1:0]    reg_rdata_i,
  output logic             nvm_re_o,
  output logic             nvm_we_o,
  output logic [NAW-1:0]   nvm_addr_o,
  output logic [DW-1:0]    nvm_wdata_o,
  input  logic [DW-1:0]    nvm_rdata_i
);
  localparam int VMAX = (RAM_WORDS > REG_WORDS) ? RAM_WORDS : REG_WORDS;
  localparam int IW   = $clog2(VMAX);
  localparam logic [DW-1:0] FLAG_OK = DW'(1);

  hib_state_t    st_q, st_d;
  logic [1:0]    qual;
  logic          lo_ok, hi_ok;
  logic          seq_run, seq_dir, seq_ram;
  logic [IW-1:0] seq_idx;
  logic          cp_busy, cp_nvm_re, cp_nvm_we;
  logic [NAW-1:0] cp_nvm_addr;
  logic [DW-1:0] cp_nvm_wdata;
  logic          copy_idle;
  logic [CNT_W-1:0] cnt_q;

  hib_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({sup_high_i, sup_low_i}),
    .qual_o(qual)
  );
  assign lo_ok = qual[0];
  assign hi_ok = qual[1];

  hib_seq #(.RAM_W(RAM_WORDS), .NGEN(GEN_REGS), .NCORE(CORE_REGS), .IW(IW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  ((st_q == ST_CLR) || (st_q == ST_REST)),
    .restore_i(st_q == ST_REST),
    .run_o    (seq_run),
    .dir_o    (seq_dir),
    .ram_o    (seq_ram),
    .idx_o    (seq_idx)
  );

  hib_copy #(.DW(DW), .RAM_W(RAM_WORDS), .IW(IW), .RAW(RAW), .GAW(GAW), .NAW(NAW)) u_copy (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_vld_i  (seq_run),
    .iss_dir_i  (seq_dir),
    .iss_ram_i  (seq_ram),
    .iss_idx_i  (seq_idx),
    .busy_o     (cp_busy),
    .ram_re_o   (ram_re_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(ram_rdata_i),
    .reg_re_o   (reg_re_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i),
    .nvm_re_o   (cp_nvm_re),
    .nvm_we_o   (cp_nvm_we),
    .nvm_addr_o (cp_nvm_addr),
    .nvm_wdata_o(cp_nvm_wdata),
    .nvm_rdata_i(nvm_rdata_i)
  );

  assign copy_idle = ~seq_run & ~cp_busy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BOOT:    st_d = ST_BOOTCHK;
      ST_BOOTCHK: st_d = (nvm_rdata_i == FLAG_OK) ? ST_REST : ST_RUN;
      ST_RUN:     if (lo_ok) st_d = ST_CLR;
      ST_CLR:     st_d = ST_SAVE;
      ST_SAVE:    if (copy_idle) st_d = ST_SET;
      ST_SET:     st_d = ST_SLEEP;
      ST_SLEEP:   if (hi_ok) st_d = ST_REST;
      ST_REST:    st_d = ST_RWAIT;
      ST_RWAIT:   if (copy_idle) st_d = ST_RUN;
      default:    st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_BOOT;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SET && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Validity-word accesses take the non-volatile port while the copy pipe is idle.
  always_comb begin
    nvm_re_o    = cp_nvm_re;
    nvm_we_o    = cp_nvm_we;
    nvm_addr_o  = cp_nvm_addr;
    nvm_wdata_o = cp_nvm_wdata;
    unique case (st_q)
      ST_BOOT: begin
        nvm_re_o   = 1'b1;
        nvm_addr_o = '0;
      end
      ST_CLR: begin
        nvm_we_o    = 1'b1;
        nvm_addr_o  = '0;
        nvm_wdata_o = '0;
      end
      ST_SET: begin
        nvm_we_o    = 1'b1;
        nvm_addr_o  = '0;
        nvm_wdata_o = FLAG_OK;
      end
      default: ;
    endcase
  end

  assign core_run_o  = (st_q == ST_RUN);
  assign mode_hib_o  = (st_q != ST_RUN);
  assign busy_o      = (st_q == ST_CLR) || (st_q == ST_SAVE) || (st_q == ST_SET) ||
                       (st_q == ST_REST) || (st_q == ST_RWAIT);
  assign hib_count_o = cnt_q;
endmodule

// File: rtl/hib_ctrl_chk.sv
module hib_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_run_o,
  input logic             mode_hib_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] hib_count_o,
  input logic             ram_we_o,
  input logic             reg_we_o,
  input logic             nvm_we_o
);
  // R8
  busy_halts_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !core_run_o);

  // R8
  vol_write_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o || reg_we_o) |-> (!core_run_o && busy_o));

  // R4
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hib_o && !busy_o) |-> !nvm_we_o);

  // R6
  no_cross_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_we_o |-> !(ram_we_o || reg_we_o));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_count_o != $past(hib_count_o)) |-> (hib_count_o == $past(hib_count_o) + 1'b1));

  // R9
  count_at_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_count_o != $past(hib_count_o)) |-> (mode_hib_o && !busy_o && $past(busy_o)));

  // R1
  mode_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run_o) |-> !mode_hib_o);
endmodule

bind hib_ctrl hib_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_run_o (core_run_o),
  .mode_hib_o (mode_hib_o),
  .busy_o     (busy_o),
  .hib_count_o(hib_count_o),
  .ram_we_o   (ram_we_o),
  .reg_we_o   (reg_we_o),
  .nvm_we_o   (nvm_we_o)
);

// File: tb/sim_hib_ctrl.sv
`timescale 1ns/1ps
module sim_hib_ctrl;
  localparam int DW = 8, RAMW = 8, NGEN = 4, NCORE = 3, CW = 2;
  localparam int REGW = NGEN + NCORE + 2;
  localparam int NVMW = 1 + RAMW + REGW;
  localparam int RAW = $clog2(RAMW), GAW = $clog2(REGW), NAW = $clog2(NVMW);

  logic clk = 1'b0, rst_n = 1'b0, sup_low = 1'b0, sup_high = 1'b1;
  logic core_run, mode_hib, busy;
  logic [CW-1:0] hcnt;
  logic ram_re, ram_we, reg_re, reg_we, nvm_re, nvm_we;
  logic [RAW-1:0] ram_addr;
  logic [GAW-1:0] reg_addr;
  logic [NAW-1:0] nvm_addr;
  logic [DW-1:0] ram_wd, reg_wd, nvm_wd, ram_rd, reg_rd, nvm_rd;

  logic [DW-1:0] ram_m [RAMW];
  logic [DW-1:0] reg_m [REGW];
  logic [DW-1:0] nvm_m [NVMW];
  logic [DW-1:0] pat_ram [RAMW];
  logic [DW-1:0] pat_reg [REGW];

  int errs = 0, checks = 0;
  int lk [256], la [256], ld [256];
  int nlog = 0;
  int ek [256], ea [256], ed [256];
  int ne = 0;

  always #2 clk = ~clk;

  hib_ctrl #(.DW(DW), .RAM_WORDS(RAMW), .GEN_REGS(NGEN), .CORE_REGS(NCORE), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_low_i(sup_low), .sup_high_i(sup_high),
    .core_run_o(core_run), .mode_hib_o(mode_hib), .busy_o(busy), .hib_count_o(hcnt),
    .ram_re_o(ram_re), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wd), .ram_rdata_i(ram_rd),
    .reg_re_o(reg_re), .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wd), .reg_rdata_i(reg_rd),
    .nvm_re_o(nvm_re), .nvm_we_o(nvm_we), .nvm_addr_o(nvm_addr), .nvm_wdata_o(nvm_wd), .nvm_rdata_i(nvm_rd)
  );

  // Memory models: one-cycle read latency, same-cycle write.
  always @(posedge clk) begin
    if (ram_we) ram_m[ram_addr] <= ram_wd;
    if (ram_re) ram_rd <= ram_m[ram_addr];
    if (reg_we) reg_m[reg_addr] <= reg_wd;
    if (reg_re) reg_rd <= reg_m[reg_addr];
    if (nvm_we) nvm_m[nvm_addr] <= nvm_wd;
    if (nvm_re) nvm_rd <= nvm_m[nvm_addr];
  end

  // Write logger (kind 0 = nvm, 1 = ram, 2 = reg).
  always @(negedge clk) begin
    if (nvm_we && nlog < 256) begin lk[nlog] = 0; la[nlog] = int'(nvm_addr); ld[nlog] = int'(nvm_wd); nlog = nlog + 1; end
    if (ram_we && nlog < 256) begin lk[nlog] = 1; la[nlog] = int'(ram_addr); ld[nlog] = int'(ram_wd); nlog = nlog + 1; end
    if (reg_we && nlog < 256) begin lk[nlog] = 2; la[nlog] = int'(reg_addr); ld[nlog] = int'(reg_wd); nlog = nlog + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int k, input int a, input int d);
    ek[ne] = k; ea[ne] = a; ed[ne] = d; ne++;
  endtask

  task automatic exp_save();
    push(0, 0, 0);
    for (int j = NGEN; j < NGEN + NCORE; j++) push(0, 1 + RAMW + j, int'(pat_reg[j]));
    for (int i = 0; i < RAMW; i++) push(0, 1 + i, int'(pat_ram[i]));
    for (int j = 0; j < NGEN; j++) push(0, 1 + RAMW + j, int'(pat_reg[j]));
    for (int j = NGEN + NCORE; j < REGW; j++) push(0, 1 + RAMW + j, int'(pat_reg[j]));
    push(0, 0, 1);
  endtask

  task automatic exp_restore();
    for (int j = 0; j < NGEN; j++) push(2, j, int'(pat_reg[j]));
    for (int i = 0; i < RAMW; i++) push(1, i, int'(pat_ram[i]));
    for (int j = NGEN; j < REGW; j++) push(2, j, int'(pat_reg[j]));
  endtask

  task automatic cmp_log(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < ne && i < nlog; i++)
      if (bad < 0 && (lk[i] != ek[i] || la[i] != ea[i] || ld[i] != ed[i])) bad = i;
    if (nlog != ne) chk(1'b0, {req, " write count"}, nlog, ne);
    else if (bad >= 0) chk(1'b0, {req, " write order/addr"}, lk[bad] * 1000 + la[bad], ek[bad] * 1000 + ea[bad]);
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic clear_log();
    nlog = 0; ne = 0;
  endtask

  task automatic load_pattern(input int seed);
    for (int i = 0; i < RAMW; i++) begin pat_ram[i] = DW'(seed * 7 + i * 13 + 3); ram_m[i] <= pat_ram[i]; end
    for (int j = 0; j < REGW; j++) begin pat_reg[j] = DW'(seed * 11 + j * 29 + 5); reg_m[j] <= pat_reg[j]; end
  endtask

  task automatic scramble();
    for (int i = 0; i < RAMW; i++) ram_m[i] <= ~pat_ram[i];
    for (int j = 0; j < REGW; j++) reg_m[j] <= ~pat_reg[j];
  endtask

  task automatic check_volatile(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < RAMW; i++) if (ram_m[i] !== pat_ram[i]) bad++;
    for (int j = 0; j < REGW; j++) if (reg_m[j] !== pat_reg[j]) bad++;
    chk(bad == 0, {req, " volatile contents"}, bad, 0);
  endtask

  task automatic wait_for(input int what, input string req);
    int t;
    t = 0;
    while (t < 5000 && !((what == 0 && mode_hib && !busy) || (what == 1 && core_run) || (what == 2 && busy))) begin
      @(negedge clk); t++;
    end
    if (t >= 5000) chk(1'b0, {req, " timeout"}, t, 0);
  endtask

  task automatic outage(input int seed_dummy);
    sup_high = 1'b0; sup_low = 1'b1;
    wait_for(0, "R9");
    sup_low = 1'b0; sup_high = 1'b1;
    wait_for(1, "R9");
    if (seed_dummy < 0) $display("unused");
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < NVMW; a++) nvm_m[a] <= '0;
    load_pattern(1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    // R1 / R7: clear validity word -> active, nothing written
    chk(core_run == 1'b1 && mode_hib == 1'b0, "R1 active after reset", int'(core_run), 1);
    chk(busy == 1'b0, "R8 idle busy", int'(busy), 0);
    chk(hcnt == 0, "R9 count reset", int'(hcnt), 0);
    chk(nlog == 0, "R7 no writes on init", nlog, 0);

    // R2: one-cycle pulse on the low flag is ignored
    clear_log();
    sup_low = 1'b1; @(negedge clk); sup_low = 1'b0;
    repeat (20) @(negedge clk);
    chk(nlog == 0 && core_run == 1'b1, "R2 glitch ignored", nlog, 0);

    // R3: full save order and content
    clear_log(); exp_save();
    sup_high = 1'b0; sup_low = 1'b1;
    wait_for(0, "R3");
    cmp_log("R3 save sequence");
    chk(nvm_m[0] == 1, "R3 validity set", int'(nvm_m[0]), 1);
    chk(core_run == 1'b0 && mode_hib == 1'b1, "R1 hibernating mode", int'(mode_hib), 1);
    chk(hcnt == 1, "R9 count after first save", int'(hcnt), 1);

    // R4: sleeping with the low flag held writes nothing more
    repeat (150) @(negedge clk);
    chk(nlog == ne, "R4 single snapshot", nlog, ne);

    // R5: restore after power loss
    scramble();
    @(negedge clk);
    clear_log(); exp_restore();
    sup_low = 1'b0; sup_high = 1'b1;
    wait_for(1, "R5");
    cmp_log("R5 restore sequence");
    check_volatile("R5");

    // R6: restore request during a save waits for the valid mark
    load_pattern(2);
    @(negedge clk);
    clear_log(); exp_save(); exp_restore();
    sup_high = 1'b0; sup_low = 1'b1;
    wait_for(2, "R6");
    sup_low = 1'b0; sup_high = 1'b1;
    wait_for(1, "R6");
    cmp_log("R6 save then restore");
    chk(hcnt == 2, "R9 count after second save", int'(hcnt), 2);

    // R7: reset with a valid snapshot restores without the high flag
    scramble();
    sup_high = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    clear_log(); exp_restore();
    rst_n = 1'b1;
    wait_for(1, "R7");
    cmp_log("R7 boot restore");
    check_volatile("R7");
    sup_high = 1'b1;

    // R7: save cut by reset leaves the snapshot invalid
    load_pattern(3);
    @(negedge clk);
    sup_high = 1'b0; sup_low = 1'b1;
    wait_for(2, "R7");
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    sup_low = 1'b0; sup_high = 1'b1;
    repeat (3) @(negedge clk);
    chk(nvm_m[0] == 0, "R7 cut save invalid", int'(nvm_m[0]), 0);
    clear_log();
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    chk(core_run == 1'b1 && nlog == 0, "R7 init after cut save", nlog, 0);

    // R9: counter saturates at its all-ones value
    for (int k = 0; k < 4; k++) begin
      outage(k);
      chk(int'(hcnt) == ((k + 1 > 3) ? 3 : k + 1), "R9 saturation", int'(hcnt), (k + 1 > 3) ? 3 : k + 1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule